// File: doc/BRIEF.md
# Inbound Message Frame Queue

This block receives messages as a stream of 32-bit beats and writes each one into a slot of a circular ring of equal-sized frames in memory. The hardware owns an enqueue index that steps forward once a message has fully and cleanly arrived. Software owns a dequeue index that it steps forward by pulsing a bit in the mode register once it has consumed the frame at the head. The queue is empty when the two indices are equal. It is full when one more enqueue would make them equal. In that case a new message is refused and a full flag is raised.

Software configures the ring through a 32-bit register port. It sets the ring base address, the entry count as a log2 code, the frame size as a log2 code, the unit enable and three interrupt enables. Three sticky status flags report a queued message, a refused message and a receive error. Writing a one to a flag clears it. The interrupt line combines the enabled conditions. All messages land in one queue. Each message starts at word 0 of its frame, and beats beyond the frame size are not written.

Top module: `inbound_frame_queue`

## Requirements
- R1: After reset the mode register reads 0x0004_0000, status reads 0, both pointers and the base read 0, irq is 0, and mem_we is 0.
- R2: The queue is empty exactly when the dequeue pointer (register index 2) equals the enqueue pointer (register index 3).
- R3: Beat k of an accepted message is written at base + index×frame_bytes + 4k, where index is the enqueue index. A clean last beat advances the enqueue pointer by one frame and sets status bit 0.
- R4: Writing the mode register (index 0) with bit 1 set advances the dequeue pointer by one frame when the queue is non-empty. It has no effect when the queue is empty, and bit 1 always reads back 0.
- R5: Mode bits 15:12 hold log2(entries)−1, giving 2 to 2048 entries. Both indices wrap to 0 after the last entry, so the pointers return to the base.
- R6: When the ring is full, a message's first beat is refused. The message causes no memory writes, the enqueue pointer is unchanged, and status bit 4 is set.
- R7: A beat with msg_err on an accepted message ends that message. It sets status bit 7, its own beat is not written, and the enqueue pointer is unchanged.
- R8: Writing status (index 1) clears each flag whose bit is 1 in the written data and leaves the others.
- R9: irq = (mode bit 5 and queue non-empty) or (mode bit 6 and status bit 7) or (mode bit 7 and status bit 4).
- R10: With mode bit 0 clear, arriving messages cause no memory writes, no status change and no pointer change.
- R11: Writing the base register (index 4) sets the ring base and returns both pointers to it.
- R12: Mode bits 18:16 hold f, and frames are 2^(8+f) bytes for f ≤ 4 (larger values act as 4). Beats past the end of a frame are not written, but the message still commits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| msg_valid | input | 1 | Message beat present this cycle |
| msg_first | input | 1 | Beat is the first of a message |
| msg_last | input | 1 | Beat is the last of a message |
| msg_err | input | 1 | Receive error on this beat |
| msg_data | input | 32 | Beat payload |
| mem_we | output | 1 | Frame memory write strobe |
| mem_addr | output | 32 | Frame memory byte address |
| mem_wdata | output | 32 | Frame memory write data |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index: 0 mode, 1 status, 2 dequeue ptr, 3 enqueue ptr, 4 base |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| irq | output | 1 | Combined interrupt |

## Verification
The bench drives the ring to one-below-capacity and sends a further message. A design that tested fullness with pointer equality would overwrite the unread head frame instead of refusing the message. Pulsing release on an empty queue catches a dequeue index that runs ahead of the enqueue index. That fault would make the queue look full of stale frames. Sending a message longer than a small frame catches a writer that spills into the next slot. An error beat in mid-message catches a design that commits a partial frame. The random phase interleaves arrivals, releases and flag clears across many wraps. This exposes off-by-one wrap masks and any loss of the queued interrupt while frames remain.

// File: rtl/ifq_pkg.sv
// Shared constants for the inbound frame queue.
// Assumes a 32-bit register port with word indices 0..4.
package ifq_pkg;
    localparam int unsigned DATA_W = 32;
    localparam int unsigned REG_AW = 3;

    // Register indices
    localparam logic [REG_AW-1:0] RA_MODE = 3'd0;
    localparam logic [REG_AW-1:0] RA_STAT = 3'd1;
    localparam logic [REG_AW-1:0] RA_DEQ  = 3'd2;
    localparam logic [REG_AW-1:0] RA_ENQ  = 3'd3;
    localparam logic [REG_AW-1:0] RA_BASE = 3'd4;

    // Mode register bit positions
    localparam int unsigned MB_EN      = 0;
    localparam int unsigned MB_REL     = 1;
    localparam int unsigned MB_IEQ     = 5;
    localparam int unsigned MB_IEE     = 6;
    localparam int unsigned MB_IEF     = 7;
    localparam int unsigned MF_RING_LO = 12;
    localparam int unsigned MF_RING_W  = 4;
    localparam int unsigned MF_FRM_LO  = 16;
    localparam int unsigned MF_FRM_W   = 3;

    // Status register bit positions
    localparam int unsigned SB_Q    = 0;
    localparam int unsigned SB_FULL = 4;
    localparam int unsigned SB_ERR  = 7;

    localparam logic [DATA_W-1:0] MODE_RST  = 32'h0004_0000;
    localparam logic [DATA_W-1:0] MODE_KEEP = 32'h0007_F0E1;

    typedef enum logic {RX_IDLE, RX_BODY} rx_state_e;
endpackage

// File: rtl/ifq_regs.sv
// Register file of the frame queue: mode, sticky status, ring base,
// read mux and interrupt combine.
// Assumes one register access per cycle; status sets win over clears.
module ifq_regs
    import ifq_pkg::*;
#(
    parameter int unsigned MIN_FRAME_LOG2 = 8,
    parameter int unsigned MAX_FRAME_LOG2 = 12,
    parameter int unsigned MAX_RING_LOG2  = 11,
    localparam int unsigned FLW = $clog2(MAX_FRAME_LOG2 + 1),
    localparam int unsigned RLW = $clog2(MAX_RING_LOG2 + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              empty,
    input  logic [DATA_W-1:0] deq_ptr,
    input  logic [DATA_W-1:0] enq_ptr,
    input  logic              set_q,
    input  logic              set_full,
    input  logic              set_err,
    output logic              enable,
    output logic              release_req,
    output logic              base_wr,
    output logic [DATA_W-1:0] base_addr,
    output logic [RLW-1:0]    ring_log2,
    output logic [FLW-1:0]    frame_log2,
    output logic              irq
);
    localparam int unsigned FRM_SPAN = MAX_FRAME_LOG2 - MIN_FRAME_LOG2;

    logic [DATA_W-1:0]    mode_q;
    logic [DATA_W-1:0]    base_q;
    logic                 st_q, st_full, st_err;
    logic                 mode_wr, stat_wr;
    logic [MF_RING_W-1:0] ring_code;
    logic [MF_FRM_W-1:0]  frm_code;

    assign mode_wr     = reg_wr && (reg_addr == RA_MODE);
    assign stat_wr     = reg_wr && (reg_addr == RA_STAT);
    assign base_wr     = reg_wr && (reg_addr == RA_BASE);
    assign release_req = mode_wr && reg_wdata[MB_REL];
    assign enable      = mode_q[MB_EN];
    assign base_addr   = base_q;

    // Holds the configuration bits of the mode register.
    always_ff @(posedge clk) begin
        if (!rst_n)       mode_q <= MODE_RST;
        else if (mode_wr) mode_q <= reg_wdata & MODE_KEEP;
    end

    // Holds the ring base address.
    always_ff @(posedge clk) begin
        if (!rst_n)       base_q <= '0;
        else if (base_wr) base_q <= reg_wdata;
    end

    // Sticky status flags: write-one-to-clear, hardware set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= 1'b0;
            st_full <= 1'b0;
            st_err  <= 1'b0;
        end else begin
            st_q    <= set_q    | (st_q    & ~(stat_wr & reg_wdata[SB_Q]));
            st_full <= set_full | (st_full & ~(stat_wr & reg_wdata[SB_FULL]));
            st_err  <= set_err  | (st_err  & ~(stat_wr & reg_wdata[SB_ERR]));
        end
    end

    // Decodes the log2 ring size with clamping to the supported maximum.
    always_comb begin
        ring_code = mode_q[MF_RING_LO +: MF_RING_W];
        if (int'(ring_code) + 1 >= int'(MAX_RING_LOG2))
            ring_log2 = RLW'(MAX_RING_LOG2);
        else
            ring_log2 = RLW'(int'(ring_code) + 1);
    end

    // Decodes the log2 frame size with clamping to the supported maximum.
    always_comb begin
        frm_code = mode_q[MF_FRM_LO +: MF_FRM_W];
        if (int'(frm_code) > int'(FRM_SPAN))
            frame_log2 = FLW'(MAX_FRAME_LOG2);
        else
            frame_log2 = FLW'(int'(MIN_FRAME_LOG2) + int'(frm_code));
    end

    // Selects the register addressed by the read index.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            RA_MODE: reg_rdata = mode_q;
            RA_STAT: begin
                reg_rdata[SB_Q]    = st_q;
                reg_rdata[SB_FULL] = st_full;
                reg_rdata[SB_ERR]  = st_err;
            end
            RA_DEQ:  reg_rdata = deq_ptr;
            RA_ENQ:  reg_rdata = enq_ptr;
            RA_BASE: reg_rdata = base_q;
            default: reg_rdata = '0;
        endcase
    end

    // Combines the enabled interrupt causes.
    always_comb begin
        irq = (mode_q[MB_IEQ] & ~empty)
            | (mode_q[MB_IEE] & st_err)
            | (mode_q[MB_IEF] & st_full);
    end

    AST_IRQ_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q[MB_IEQ] && !empty) |-> irq); // R9
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        set_err |=> st_err); // R7
    AST_FULL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        set_full |=> st_full); // R6
endmodule

// File: rtl/ifq_ring.sv
// Enqueue/dequeue indices of the frame ring and their byte pointers.
// Assumes the ring size is not changed while frames are queued.
module ifq_ring
    import ifq_pkg::*;
#(
    parameter int unsigned MAX_FRAME_LOG2 = 12,
    parameter int unsigned MAX_RING_LOG2  = 11,
    localparam int unsigned FLW = $clog2(MAX_FRAME_LOG2 + 1),
    localparam int unsigned RLW = $clog2(MAX_RING_LOG2 + 1),
    localparam int unsigned IW  = MAX_RING_LOG2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              base_wr,
    input  logic [DATA_W-1:0] base_addr,
    input  logic [RLW-1:0]    ring_log2,
    input  logic [FLW-1:0]    frame_log2,
    input  logic              commit,
    input  logic              release_req,
    output logic              empty,
    output logic              full,
    output logic [DATA_W-1:0] enq_ptr,
    output logic [DATA_W-1:0] deq_ptr
);
    logic [IW-1:0] enq_idx, deq_idx;
    logic [IW-1:0] idx_mask;
    logic [IW-1:0] enq_next, deq_next;

    assign idx_mask = ~({IW{1'b1}} << ring_log2);
    assign enq_next = (enq_idx + IW'(1)) & idx_mask;
    assign deq_next = (deq_idx + IW'(1)) & idx_mask;
    assign empty    = (enq_idx == deq_idx);
    assign full     = (enq_next == deq_idx);
    assign enq_ptr  = base_addr + (DATA_W'(enq_idx) << frame_log2);
    assign deq_ptr  = base_addr + (DATA_W'(deq_idx) << frame_log2);

    // Hardware side: steps the enqueue index on each committed message.
    always_ff @(posedge clk) begin
        if (!rst_n || base_wr) enq_idx <= '0;
        else if (commit)       enq_idx <= enq_next;
    end

    // Software side: steps the dequeue index on a release of a queued frame.
    always_ff @(posedge clk) begin
        if (!rst_n || base_wr)        deq_idx <= '0;
        else if (release_req && !empty) deq_idx <= deq_next;
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> !full); // R6
    AST_EMPTY_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (release_req && empty && !base_wr) |=> $stable(deq_idx)); // R4
    AST_BASE_REWIND: assert property (@(posedge clk) disable iff (!rst_n)
        base_wr |=> (enq_ptr == deq_ptr)); // R11
endmodule

// File: rtl/ifq_rx.sv
// Receive sequencer: accepts or refuses a message on its first beat,
// writes beats into the current frame and commits on a clean last beat.
// Assumes memory accepts one write per cycle without back-pressure.
module ifq_rx
    import ifq_pkg::*;
#(
    parameter int unsigned MAX_FRAME_LOG2 = 12,
    localparam int unsigned FLW = $clog2(MAX_FRAME_LOG2 + 1),
    localparam int unsigned OW  = MAX_FRAME_LOG2 - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              full,
    input  logic [DATA_W-1:0] frame_addr,
    input  logic [FLW-1:0]    frame_log2,
    input  logic              msg_valid,
    input  logic              msg_first,
    input  logic              msg_last,
    input  logic              msg_err,
    input  logic [DATA_W-1:0] msg_data,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              commit,
    output logic              set_full,
    output logic              set_err
);
    rx_state_e     st_q;
    logic [OW-1:0] off_q, off_cur, off_nxt;
    logic          start, take, in_frame;
    logic [FLW-1:0] words_log2;

    assign start      = msg_valid && msg_first;
    assign take       = start ? (enable && !full) : (st_q == RX_BODY && enable);
    assign off_cur    = start ? '0 : off_q;
    assign words_log2 = frame_log2 - FLW'(2);
    assign in_frame   = ((off_cur >> words_log2) == '0);
    assign off_nxt    = in_frame ? off_cur + OW'(1) : off_cur;

    assign mem_we    = msg_valid && take && !msg_err && in_frame;
    assign mem_addr  = frame_addr + (DATA_W'(off_cur) << 2);
    assign mem_wdata = msg_data;
    assign commit    = msg_valid && take && msg_last && !msg_err;
    assign set_err   = msg_valid && take && msg_err;
    assign set_full  = start && enable && full;

    // Tracks whether a message is in progress and its next word offset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= RX_IDLE;
            off_q <= '0;
        end else if (msg_valid) begin
            if (take && !msg_last && !msg_err) begin
                st_q  <= RX_BODY;
                off_q <= off_nxt;
            end else begin
                st_q  <= RX_IDLE;
                off_q <= '0;
            end
        end
    end

    AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> !mem_we); // R10
    AST_FULL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (start && full) |-> !mem_we); // R6
    AST_ERR_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        msg_err |-> !commit); // R7
endmodule

// File: rtl/inbound_frame_queue.sv
// Top of the inbound frame queue: register file, ring indices and
// receive sequencer. Assumes a single queue for all arriving messages.
module inbound_frame_queue
    import ifq_pkg::*;
#(
    parameter int unsigned MIN_FRAME_LOG2 = 8,
    parameter int unsigned MAX_FRAME_LOG2 = 12,
    parameter int unsigned MAX_RING_LOG2  = 11
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        msg_valid,
    input  logic        msg_first,
    input  logic        msg_last,
    input  logic        msg_err,
    input  logic [31:0] msg_data,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic        reg_wr,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        irq
);
    localparam int unsigned FLW = $clog2(MAX_FRAME_LOG2 + 1);
    localparam int unsigned RLW = $clog2(MAX_RING_LOG2 + 1);

    logic              empty, full, enable, release_req, base_wr;
    logic              commit, set_full, set_err;
    logic [DATA_W-1:0] base_addr, enq_ptr, deq_ptr;
    logic [RLW-1:0]    ring_log2;
    logic [FLW-1:0]    frame_log2;

    ifq_regs #(
        .MIN_FRAME_LOG2(MIN_FRAME_LOG2),
        .MAX_FRAME_LOG2(MAX_FRAME_LOG2),
        .MAX_RING_LOG2 (MAX_RING_LOG2)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .empty      (empty),
        .deq_ptr    (deq_ptr),
        .enq_ptr    (enq_ptr),
        .set_q      (commit),
        .set_full   (set_full),
        .set_err    (set_err),
        .enable     (enable),
        .release_req(release_req),
        .base_wr    (base_wr),
        .base_addr  (base_addr),
        .ring_log2  (ring_log2),
        .frame_log2 (frame_log2),
        .irq        (irq)
    );

    ifq_ring #(
        .MAX_FRAME_LOG2(MAX_FRAME_LOG2),
        .MAX_RING_LOG2 (MAX_RING_LOG2)
    ) u_ring (
        .clk        (clk),
        .rst_n      (rst_n),
        .base_wr    (base_wr),
        .base_addr  (base_addr),
        .ring_log2  (ring_log2),
        .frame_log2 (frame_log2),
        .commit     (commit),
        .release_req(release_req),
        .empty      (empty),
        .full       (full),
        .enq_ptr    (enq_ptr),
        .deq_ptr    (deq_ptr)
    );

    ifq_rx #(
        .MAX_FRAME_LOG2(MAX_FRAME_LOG2)
    ) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .full      (full),
        .frame_addr(enq_ptr),
        .frame_log2(frame_log2),
        .msg_valid (msg_valid),
        .msg_first (msg_first),
        .msg_last  (msg_last),
        .msg_err   (msg_err),
        .msg_data  (msg_data),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .commit    (commit),
        .set_full  (set_full),
        .set_err   (set_err)
    );

    AST_EMPTY_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> (enq_ptr == deq_ptr)); // R2
endmodule

// File: tb/tb_inbound_frame_queue.sv
`timescale 1ns/1ps
module tb_inbound_frame_queue;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        msg_valid = 0, msg_first = 0, msg_last = 0, msg_err = 0;
    logic [31:0] msg_data = '0;
    logic        mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        reg_wr = 0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // Reference model state
    logic [31:0] m_base = 0, m_mode = 32'h0004_0000;
    int          m_enq = 0, m_deq = 0;
    bit          s_q = 0, s_full = 0, s_err = 0;

    inbound_frame_queue dut (
        .clk(clk), .rst_n(rst_n),
        .msg_valid(msg_valid), .msg_first(msg_first), .msg_last(msg_last),
        .msg_err(msg_err), .msg_data(msg_data),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    always #4 clk = ~clk;

    function automatic int ents();
        int c = int'(m_mode[15:12]) + 1;
        if (c > 11) c = 11;
        return 1 << c;
    endfunction
    function automatic int flog();
        int f = int'(m_mode[18:16]);
        if (f > 4) f = 4;
        return 8 + f;
    endfunction
    function automatic logic [31:0] ptr(input int idx);
        return m_base + (32'(idx) << flog());
    endfunction
    function automatic bit m_full();
        return ((m_enq + 1) % ents()) == m_deq;
    endfunction
    function automatic logic [31:0] m_stat();
        return {24'd0, s_err, 2'd0, s_full, 3'd0, s_q};
    endfunction
    function automatic logic m_irq();
        return (m_mode[5] && m_enq != m_deq) || (m_mode[6] && s_err) || (m_mode[7] && s_full);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wr_mode(input logic [31:0] v);
        if (v[1] && m_enq != m_deq) m_deq = (m_deq + 1) % ents();
        wr(3'd0, v);
        m_mode = v & 32'h0007_F0E1;
    endtask

    task automatic wr_base(input logic [31:0] v);
        wr(3'd4, v);
        m_base = v; m_enq = 0; m_deq = 0;
    endtask

    task automatic wr_stat(input logic [31:0] v);
        wr(3'd1, v);
        if (v[0]) s_q = 0;
        if (v[4]) s_full = 0;
        if (v[7]) s_err = 0;
    endtask

    // Sends n beats; err_at < n marks the aborting beat.
    task automatic send(input string req, input int n, input int err_at);
        bit acc   = m_mode[0] && !m_full();
        int words = 1 << (flog() - 2);
        bit stop  = 0;
        for (int i = 0; i < n && !stop; i++) begin
            @(negedge clk);
            msg_valid = 1; msg_first = (i == 0);
            msg_err   = (i == err_at);
            msg_last  = (i == n - 1) || (i == err_at);
            msg_data  = $urandom;
            #1;
            check({req, " write strobe"}, 32'(mem_we),
                  32'(acc && i < words && i != err_at));
            if (acc && i < words && i != err_at) begin
                check({req, " write addr"}, mem_addr, ptr(m_enq) + 32'(4 * i));
                check({req, " write data"}, mem_wdata, msg_data);
            end
            if (i == err_at) stop = 1;
        end
        @(negedge clk);
        msg_valid = 0; msg_first = 0; msg_last = 0; msg_err = 0;
        if (acc && err_at < n) s_err = 1;
        else if (acc) begin m_enq = (m_enq + 1) % ents(); s_q = 1; end
        else if (m_mode[0]) s_full = 1;
    endtask

    task automatic chk_state(input string req);
        logic [31:0] v;
        rd(3'd2, v); check({req, " deq ptr"}, v, ptr(m_deq));
        rd(3'd3, v); check({req, " enq ptr"}, v, ptr(m_enq));
        rd(3'd1, v); check({req, " status"}, v, m_stat());
        check({req, " irq"}, 32'(irq), 32'(m_irq()));
    endtask

    initial begin
        logic [31:0] v;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        rd(3'd0, v); check("R1 mode reset", v, 32'h0004_0000);
        rd(3'd4, v); check("R1 base reset", v, 32'h0);
        check("R1 mem_we reset", 32'(mem_we), 32'h0);
        chk_state("R1");

        // R11 base write rewinds both pointers; R2 empty by equality
        wr_base(32'h2000_0000);
        chk_state("R11");
        // 4 entries, 4 KB frames, enable, queued-irq enable
        wr_mode(32'h0004_1021);
        check("R9 irq quiet when empty", 32'(irq), 32'h0);

        // R3 first message and two more until full
        send("R3", 3, 99);
        chk_state("R3");
        send("R3", 5, 99);
        send("R3", 1, 99);
        chk_state("R2 full ring");

        // R6 refused message
        send("R6", 2, 99);
        chk_state("R6");

        // R8 write-one-to-clear, one flag at a time
        wr_stat(32'h10); chk_state("R8 clear full");
        wr_stat(32'h01); chk_state("R8 clear queued");
        check("R9 irq while non-empty", 32'(irq), 32'h1);

        // R4 releases, bit 1 reads back as 0
        for (int k = 0; k < 3; k++) wr_mode(32'h0004_1023);
        rd(3'd0, v); check("R4 release bit reads 0", v, 32'h0004_1021);
        chk_state("R4 drained");
        wr_mode(32'h0004_1023);
        chk_state("R4 release on empty");

        // R5 wrap back to base
        send("R5", 2, 99);
        chk_state("R5 wrap");
        rd(3'd3, v); check("R5 enq back at base", v, 32'h2000_0000);

        // R7 error mid-message with error irq enabled
        wr_mode(32'h0004_1061);
        send("R7", 3, 1);
        chk_state("R7");
        wr_stat(32'h91);

        // R10 disabled unit ignores arrivals
        wr_mode(32'h0004_1060);
        send("R10", 3, 99);
        chk_state("R10");

        // R12 256-byte frames truncate long messages
        wr_mode(32'h0000_1021);
        wr_base(32'h3000_0000);
        send("R12", 66, 99);
        chk_state("R12");
        rd(3'd3, v); check("R12 enq step 256B", v, 32'h3000_0100);

        // Random phase: 8 entries, 1 KB frames
        wr_base(32'h4000_0000);
        wr_mode(32'h0002_20A1);
        for (int it = 0; it < 400; it++) begin
            int r = int'($urandom % 4);
            if (r < 2) begin
                int n = 1 + int'($urandom % 8);
                int e = ($urandom % 8 == 0) ? int'($urandom % n) : 99;
                send("R3 random", n, e);
            end else if (r == 2) begin
                wr_mode(m_mode | 32'h2);
            end else begin
                wr_stat(32'h91);
            end
            chk_state("R9 random");
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog act=%h exp=%h", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule